// File: doc/BRIEF.md
# Asymmetric Block Lock Manager

This block sits beside a 4M x 16 non-volatile array and decides whether each program or erase request may go ahead. It splits a 22-bit word address into a block number for a layout that mixes eight small parameter blocks of 4K words with 127 large main blocks of 32K words. That makes 135 blocks in all. A static strap input puts the parameter blocks either at address 0 or at the highest addresses.

Each block keeps one of three protection states: open, locked or frozen ("locked-down"). Lock, unlock and freeze requests change the state of the addressed block on the next clock edge. A request in the following cycle therefore already sees the new state. A program-voltage lockout input denies every program and erase request, whatever state the blocks hold. The allow/deny decision and the addressed block's state are combinational outputs. A sticky error flag records every request that was refused because its block was protected.

Top module: `blk_lock_mgr`

## Requirements
- R1: With `top_params`=0, address a maps to block a/4096 when a<32768, and to block a/32768+7 otherwise (blocks 8..134), shown on `blk_index` in the same cycle.
- R2: With `top_params`=1, address a maps to block a/32768 when a<127*32768 (blocks 0..126), and to block 127+(a-127*32768)/4096 otherwise (blocks 127..134).
- R3: After reset every block is locked and `prot_err` is 0.
- R4: `blk_state` shows the addressed block's state in the same cycle, encoded 2'b00 open, 2'b01 locked, 2'b11 frozen; 2'b10 never appears.
- R5: Operation codes on `req_op` with `req_valid`=1 are 0 idle, 1 lock, 2 unlock, 3 freeze, 4 program, 5 erase; 6 and 7 have no effect. Lock moves an open block to locked, freeze moves any block to frozen, and the new state is visible from the next cycle.
- R6: Unlock moves a locked block to open and leaves an open block unchanged.
- R7: A frozen block ignores unlock and lock and leaves the frozen state only through reset.
- R8: `allow` is 1 only for a valid program or erase request (code 4 or 5) to an open block while `vpp_lockout` is 0. `deny` is 1 for every other valid program or erase request, and both are 0 for all other inputs.
- R9: While `vpp_lockout` is 1, every program or erase request is denied, including to open blocks.
- R10: A valid program or erase request to a locked or frozen block sets `prot_err` from the next cycle until reset. A denial caused only by `vpp_lockout` does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| top_params | input | 1 | Strap: 1 places parameter blocks at the top, 0 at the bottom |
| vpp_lockout | input | 1 | Program-voltage lockout, denies all program and erase |
| req_valid | input | 1 | Request qualifier |
| req_op | input | 3 | Operation code (see R5) |
| req_addr | input | 22 | Word address of the request |
| allow | output | 1 | Program or erase request permitted |
| deny | output | 1 | Program or erase request refused |
| blk_index | output | 8 | Block number of `req_addr` |
| blk_state | output | 2 | Protection state of the addressed block |
| prot_err | output | 1 | Sticky protection-violation flag |

## Verification
`blk_index`, `blk_state`, `allow` and `deny` are due in the same cycle as the request, so the bench drives inputs on the falling edge and compares these outputs one time unit later, before the rising edge. A state change and a `prot_err` update appear one rising edge after the request. The bench's model applies the request's effect only after it has compared the current cycle, and the next step's comparison then sees the effect on the following falling edge. Random requests are aimed at the two ends of the address space, where the parameter blocks and the main-block boundary lie, and directed steps cover the strap boundaries, the freeze-then-reset sequence and voltage-only denial.

// File: rtl/blp_pkg.sv
package blp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_LOCK   = 3'd1,
    OP_UNLOCK = 3'd2,
    OP_FREEZE = 3'd3,
    OP_PROG   = 3'd4,
    OP_ERASE  = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PS_OPEN   = 2'b00,
    PS_LOCK   = 2'b01,
    PS_FROZEN = 2'b11
  } prot_e;

  // Protection transition for one block under one request.
  function automatic prot_e next_prot(input prot_e cur, input op_e op);
    prot_e nxt;
    nxt = cur;
    case (op)
      OP_LOCK:   nxt = (cur == PS_FROZEN) ? PS_FROZEN : PS_LOCK;
      OP_UNLOCK: nxt = (cur == PS_LOCK) ? PS_OPEN : cur;
      OP_FREEZE: nxt = PS_FROZEN;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

  function automatic logic is_state_op(input op_e op);
    return (op == OP_LOCK) || (op == OP_UNLOCK) || (op == OP_FREEZE);
  endfunction

  function automatic logic is_write_op(input op_e op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

endpackage

// File: rtl/blp_addr_decode.sv
module blp_addr_decode #(
  parameter int SLOT_W = 7,
  parameter int SUB_W  = 3,
  parameter int IDX_W  = 8
) (
  input  logic [SLOT_W+SUB_W-1:0] hi_addr,
  input  logic                    top_params,
  output logic [IDX_W-1:0]        blk_idx
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int SUBS  = 1 << SUB_W;

  logic [SLOT_W-1:0] slot;
  logic [SUB_W-1:0]  sub;

  assign slot = hi_addr[SLOT_W+SUB_W-1:SUB_W];
  assign sub  = hi_addr[SUB_W-1:0];

  // One slot is split into parameter blocks; it is the last slot for the
  // top variant and the first slot for the bottom variant.
  function automatic logic [IDX_W-1:0] map_block(input logic [SLOT_W-1:0] s,
                                                 input logic [SUB_W-1:0]  p,
                                                 input logic              top);
    if (top) begin
      if (s == SLOT_W'(SLOTS - 1)) return IDX_W'(SLOTS - 1) + IDX_W'(p);
      else                         return IDX_W'(s);
    end else begin
      if (s == '0) return IDX_W'(p);
      else         return IDX_W'(s) + IDX_W'(SUBS - 1);
    end
  endfunction

  assign blk_idx = map_block(slot, sub, top_params);

endmodule

// File: rtl/blp_state_array.sv
module blp_state_array
  import blp_pkg::*;
#(
  parameter int NBLK  = 135,
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_en,
  input  op_e                   op,
  input  logic [IDX_W-1:0]      blk_idx,
  output logic [NBLK-1:0][1:0]  st_vec
);

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    prot_e q;
    logic  hit;
    assign hit = upd_en && (blk_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= PS_LOCK;
      else if (hit) q <= next_prot(q, op);
    end
    assign st_vec[g] = q;
  end

endmodule

// File: rtl/blp_access_gate.sv
module blp_access_gate
  import blp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  op_e   op,
  input  prot_e cur_state,
  input  logic  vpp_lockout,
  output logic  allow,
  output logic  deny,
  output logic  prot_hit,
  output logic  prot_err
);
  logic wr_req;

  assign wr_req   = req_valid && is_write_op(op);
  assign allow    = wr_req && (cur_state == PS_OPEN) && !vpp_lockout;
  assign deny     = wr_req && !allow;
  assign prot_hit = wr_req && (cur_state != PS_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_err <= 1'b0;
    else        prot_err <= prot_err | prot_hit;
  end

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
  import blp_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int MAIN_SHIFT  = 15,
  parameter int PARAM_SHIFT = 12,
  localparam int SLOT_W = ADDR_W - MAIN_SHIFT,
  localparam int SUB_W  = MAIN_SHIFT - PARAM_SHIFT,
  localparam int NBLK   = (1 << SLOT_W) - 1 + (1 << SUB_W),
  localparam int IDX_W  = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              top_params,
  input  logic              vpp_lockout,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              allow,
  output logic              deny,
  output logic [IDX_W-1:0]  blk_index,
  output logic [1:0]        blk_state,
  output logic              prot_err
);
  op_e                 op;
  prot_e               cur_state;
  logic                upd_en;
  logic                prot_hit;
  logic [NBLK-1:0][1:0] st_vec;
  logic                unused_low;

  assign op         = op_e'(req_op);
  assign upd_en     = req_valid && is_state_op(op);
  assign unused_low = ^req_addr[PARAM_SHIFT-1:0];

  blp_addr_decode #(.SLOT_W(SLOT_W), .SUB_W(SUB_W), .IDX_W(IDX_W)) u_dec (
    .hi_addr    (req_addr[ADDR_W-1:PARAM_SHIFT]),
    .top_params (top_params),
    .blk_idx    (blk_index)
  );

  blp_state_array #(.NBLK(NBLK), .IDX_W(IDX_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .op      (op),
    .blk_idx (blk_index),
    .st_vec  (st_vec)
  );

  assign cur_state = prot_e'(st_vec[blk_index]);
  assign blk_state = cur_state;

  blp_access_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .op          (op),
    .cur_state   (cur_state),
    .vpp_lockout (vpp_lockout),
    .allow       (allow),
    .deny        (deny),
    .prot_hit    (prot_hit),
    .prot_err    (prot_err)
  );

endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
  parameter int NBLK  = 135,
  parameter int IDX_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 vpp_lockout,
  input logic                 req_valid,
  input logic [2:0]           req_op,
  input logic                 allow,
  input logic                 deny,
  input logic [IDX_W-1:0]     blk_index,
  input logic [1:0]           blk_state,
  input logic                 prot_err,
  input logic                 prot_hit,
  input logic [NBLK-1:0][1:0] st_vec
);

  p_index_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(blk_index) < NBLK);

  p_state_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_state != 2'b10);

  p_lock_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && blk_state != 2'b11)
      |=> st_vec[$past(blk_index)] == 2'b01);

  p_freeze_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) |=> st_vec[$past(blk_index)] == 2'b11);

  p_unlock_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && blk_state == 2'b01)
      |=> st_vec[$past(blk_index)] == 2'b00);

  p_frozen_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_state == 2'b11) |=> st_vec[$past(blk_index)] == 2'b11);

  p_protected_no_allow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_state != 2'b00) |-> !allow);

  p_allow_deny_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(allow && deny));

  p_vpp_denies_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_lockout |-> !allow);

  p_hit_sets_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> prot_err);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err);

endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.NBLK(NBLK), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vpp_lockout (vpp_lockout),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .allow       (allow),
  .deny        (deny),
  .blk_index   (blk_index),
  .blk_state   (blk_state),
  .prot_err    (prot_err),
  .prot_hit    (prot_hit),
  .st_vec      (st_vec)
);

// File: tb/blk_lock_mgr_tb.sv
module blk_lock_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 135;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        top_params = 1'b0;
  logic        vpp_lockout = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [21:0] req_addr = '0;
  logic        allow, deny, prot_err;
  logic [7:0]  blk_index;
  logic [1:0]  blk_state;

  int checks = 0;
  int fails  = 0;
  logic [1:0] model [NB];
  logic       model_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .top_params(top_params), .vpp_lockout(vpp_lockout),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .allow(allow), .deny(deny), .blk_index(blk_index), .blk_state(blk_state),
    .prot_err(prot_err)
  );

  function automatic int exp_index(input int a, input logic top);
    if (top) return (a >= 127*32768) ? 127 + (a - 127*32768) / 4096 : a / 32768;
    else     return (a < 32768) ? a / 4096 : a / 32768 + 7;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic top);
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; top_params = top; vpp_lockout = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) model[i] = 2'b01;
    model_err = 1'b0;
  endtask

  // Drive one request, compare same-cycle outputs, then advance the model.
  task automatic step(input int op, input int a, input logic vpp);
    int   idx;
    logic pe, exp_allow;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = 22'(a); vpp_lockout = vpp;
    #1;
    idx       = exp_index(a, top_params);
    pe        = (op == 4) || (op == 5);
    exp_allow = pe && (model[idx] == 2'b00) && !vpp;
    chk(top_params ? "R2 index" : "R1 index", int'(blk_index), idx);
    chk("R4 state", int'(blk_state), int'(model[idx]));
    chk(vpp ? "R9 allow" : "R8 allow", int'(allow), int'(exp_allow));
    chk(vpp ? "R9 deny" : "R8 deny", int'(deny), int'(pe && !exp_allow));
    chk("R10 err", int'(prot_err), int'(model_err));
    if (pe && model[idx] != 2'b00) model_err = 1'b1;
    case (op)
      1: if (model[idx] != 2'b11) model[idx] = 2'b01;
      2: if (model[idx] == 2'b01) model[idx] = 2'b00;
      3: model[idx] = 2'b11;
      default: ;
    endcase
  endtask

  task automatic peek(input string tag, input int a, input int exp_st);
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd0; req_addr = 22'(a); vpp_lockout = 1'b0;
    #1;
    chk(tag, int'(blk_state), exp_st);
  endtask

  function automatic int rnd_addr();
    int r;
    r = $urandom % 4;
    if (r == 0) return $urandom % 65536;
    if (r == 1) return 4194304 - 1 - ($urandom % 65536);
    return $urandom % 4194304;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R3: reset state, bottom strap
    do_reset(1'b0);
    peek("R3 reset state", 0, 1);
    peek("R3 reset state", 4194303, 1);
    chk("R3 reset err", int'(prot_err), 0);
    // R1 boundaries
    step(0, 0, 0); step(0, 4095, 0); step(0, 4096, 0); step(0, 32767, 0);
    step(0, 32768, 0); step(0, 4194303, 0);
    // R8: program locked block is denied and sets error (R10)
    step(4, 4096, 0);
    step(2, 4096, 0);              // R6 unlock from locked
    peek("R6 unlocked", 4096, 0);
    step(2, 4096, 0);              // R6 unlock of open block keeps it open
    peek("R6 stays open", 4096, 0);
    step(5, 4096, 0);              // R8 erase open block allowed
    step(4, 4096, 1);              // R9 vpp denies open block
    step(1, 4096, 0);              // R5 lock next cycle
    peek("R5 locked", 4096, 1);
    // R10: vpp-only denial must not raise the flag
    do_reset(1'b0);
    step(2, 100000, 0);
    step(4, 100000, 1);
    step(0, 100000, 0);
    chk("R10 vpp no err", int'(prot_err), 0);
    // R7: freeze ignores unlock and lock, cleared by reset
    step(3, 200000, 0);
    peek("R5 frozen", 200000, 3);
    step(2, 200000, 0);
    peek("R7 unlock ignored", 200000, 3);
    step(1, 200000, 0);
    peek("R7 lock ignored", 200000, 3);
    step(6, 200000, 0); step(7, 200000, 0);
    peek("R5 reserved ops", 200000, 3);
    do_reset(1'b0);
    peek("R7 reset clears", 200000, 1);
    // R2 boundaries, top strap
    do_reset(1'b1);
    step(0, 0, 0); step(0, 127*32768 - 1, 0); step(0, 127*32768, 0);
    step(0, 127*32768 + 4095, 0); step(0, 127*32768 + 4096, 0); step(0, 4194303, 0);
    // Random mix, both straps
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass == 0);
      for (int n = 0; n < 3000; n++)
        step($urandom % 8, rnd_addr(), ($urandom % 8) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule